// File: doc/BRIEF.md
# Selectable Test Pattern Generator

This block produces a sequence of 32-bit words for self-test logic. The sequence follows one of five fixed rules, and the same sequence can be used to fill a memory or a bus burst and later to check it. A load strobe captures a pattern select code and puts that pattern's seed word on the output. After that, each advance strobe replaces the output with the word the captured rule derives from the current word.

The block stores only two things: the captured pattern code and the current word. Select codes without a rule give a constant zero stream. The output is taken directly from a register, so the word that goes with a strobe appears on the clock edge where the strobe is sampled.

Top module: `seqgen_top`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) clears data_o to 0x00000000 and selects pattern 0, so an advance right after reset gives 0x00000004.
- R2: Pattern code 0 has the seed 0x00000000. Its next word is the current word plus 4, modulo 2^32.
- R3: Pattern code 1 has the seed 0xFFFFFFFF. Its next word is the bitwise inverse of (the inverted current word plus 4).
- R4: Pattern code 2 has the seed 0x00000001. Its next word is the current word rotated left by one bit, so bit 31 moves into bit 0.
- R5: Pattern code 3 has the seed 0xFFFFFFFE and uses the same rotate-left-by-one rule as pattern code 2.
- R6: Pattern code 4 has the seed 0xFFFFFFFF. To form its next word, bit 0 of the current word is first replaced by bit 21 XOR bit 5, and the result is then rotated left by one bit.
- R7: Every select code from 5 to 15 gives a seed of 0x00000000 and a next word of 0x00000000.
- R8: When load_i and adv_i are both high at the same edge, the load wins: data_o becomes the seed of sel_i.
- R9: data_o changes only at an edge where load_i or adv_i is high. At any other edge, changes on sel_i have no effect on data_o.
- R10: The pattern code is captured at load time. Advances use the captured code, whatever value sel_i holds afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| sel_i | input | 4 | Pattern select code, sampled when load_i is high |
| load_i | input | 1 | Capture sel_i and output its seed |
| adv_i | input | 1 | Step to the next word of the captured pattern |
| data_o | output | 32 | Current word of the sequence (registered) |

## Verification
Each of the five rules is loaded and then stepped far enough for the pattern to show where it differs from the others. The rotate patterns are stepped past 32 advances so that a missing carry from bit 31 into bit 0 would be caught. The tapped rotate is stepped long enough for bits 5 and 21 to take both values. The increment and inverted-increment patterns tell an added step apart from a subtracted one. Codes 5, 9 and 15 show the zero stream. Mixed strobes, idle edges with sel_i toggling, and sel_i changed after a load show the load priority, the hold behaviour and that the code is captured at load.

// File: rtl/seqgen_pkg.sv
package seqgen_pkg;

    // Pattern codes. The numeric values are the select encoding seen at the port.
    localparam int unsigned PAT_INC   = 0;  // add step
    localparam int unsigned PAT_DEC   = 1;  // inverted add step
    localparam int unsigned PAT_WALK1 = 2;  // single one rotating left
    localparam int unsigned PAT_WALK0 = 3;  // single zero rotating left
    localparam int unsigned PAT_TAP   = 4;  // tapped rotate
    localparam int unsigned NUM_PAT   = 5;

endpackage

// File: rtl/seqgen_seed.sv
module seqgen_seed
    import seqgen_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned SEL_W  = 4
) (
    input  logic [SEL_W-1:0]  sel,
    output logic [DATA_W-1:0] seed
);

    localparam logic [DATA_W-1:0] ALL_ONES = {DATA_W{1'b1}};
    localparam logic [DATA_W-1:0] LSB_ONE  = DATA_W'(1);

    always_comb begin
        seed = '0;
        if (sel == SEL_W'(PAT_INC))        seed = '0;
        else if (sel == SEL_W'(PAT_DEC))   seed = ALL_ONES;
        else if (sel == SEL_W'(PAT_WALK1)) seed = LSB_ONE;
        else if (sel == SEL_W'(PAT_WALK0)) seed = ~LSB_ONE;
        else if (sel == SEL_W'(PAT_TAP))   seed = ALL_ONES;
    end

endmodule

// File: rtl/seqgen_step.sv
module seqgen_step
    import seqgen_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned SEL_W  = 4,
    parameter int unsigned STEP   = 4,
    parameter int unsigned TAP_HI = 21,
    parameter int unsigned TAP_LO = 5
) (
    input  logic [SEL_W-1:0]  pat,
    input  logic [DATA_W-1:0] cur,
    output logic [DATA_W-1:0] nxt
);

    localparam logic [DATA_W-1:0] STEP_V = DATA_W'(STEP);

    logic [DATA_W-1:0] cand [NUM_PAT];

    for (genvar g = 0; g < NUM_PAT; g++) begin : g_rule
        if (g == PAT_INC) begin : g_inc
            assign cand[g] = cur + STEP_V;
        end else if (g == PAT_DEC) begin : g_dec
            assign cand[g] = ~((~cur) + STEP_V);
        end else if (g == PAT_TAP) begin : g_tap
            // bit 0 replaced by the tap XOR, then rotated left
            assign cand[g] = {cur[DATA_W-2:1], cur[TAP_HI] ^ cur[TAP_LO], cur[DATA_W-1]};
        end else begin : g_rot
            assign cand[g] = {cur[DATA_W-2:0], cur[DATA_W-1]};
        end
    end

    always_comb begin
        nxt = '0;
        for (int i = 0; i < NUM_PAT; i++) begin
            if (pat == SEL_W'(i)) nxt = cand[i];
        end
    end

endmodule

// File: rtl/seqgen_top.sv
module seqgen_top
    import seqgen_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned SEL_W  = 4,
    parameter int unsigned STEP   = 4,
    parameter int unsigned TAP_HI = 21,
    parameter int unsigned TAP_LO = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SEL_W-1:0]  sel_i,
    input  logic              load_i,
    input  logic              adv_i,
    output logic [DATA_W-1:0] data_o
);

    typedef struct packed {
        logic [SEL_W-1:0]  pat;
        logic [DATA_W-1:0] word;
    } gen_state_t;

    gen_state_t st_d, st_q;
    logic [DATA_W-1:0] seed_w;
    logic [DATA_W-1:0] next_w;

    seqgen_seed #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_seed (
        .sel  (sel_i),
        .seed (seed_w)
    );

    seqgen_step #(
        .DATA_W(DATA_W), .SEL_W(SEL_W), .STEP(STEP),
        .TAP_HI(TAP_HI), .TAP_LO(TAP_LO)
    ) u_step (
        .pat (st_q.pat),
        .cur (st_q.word),
        .nxt (next_w)
    );

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.pat  = sel_i;
            st_d.word = seed_w;
        end else if (adv_i) begin
            st_d.word = next_w;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.pat  <= SEL_W'(PAT_INC);
            st_q.word <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign data_o = st_q.word;

    // R1
    reset_clear_chk: assert property (@(posedge clk) rst |=> (data_o == '0));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!load_i && !adv_i) |=> $stable(data_o));

    // R2
    inc_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!load_i && adv_i && st_q.pat == SEL_W'(PAT_INC))
        |=> (data_o == $past(data_o) + DATA_W'(STEP)));

    // R4
    walk_rot_chk: assert property (@(posedge clk) disable iff (rst)
        (!load_i && adv_i && st_q.pat == SEL_W'(PAT_WALK1))
        |=> (data_o == {$past(data_o[DATA_W-2:0]), $past(data_o[DATA_W-1])}));

    // R5
    walk0_seed_chk: assert property (@(posedge clk) disable iff (rst)
        (load_i && sel_i == SEL_W'(PAT_WALK0)) |=> (data_o == ~DATA_W'(1)));

    // R7
    unsup_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (!load_i && adv_i && st_q.pat >= SEL_W'(NUM_PAT)) |=> (data_o == '0));

    // R8
    load_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (load_i && adv_i && sel_i == SEL_W'(PAT_WALK1)) |=> (data_o == DATA_W'(1)));

endmodule

// File: tb/seqgen_top_tb.sv
module seqgen_top_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  sel_i = '0;
    logic        load_i = 1'b0;
    logic        adv_i = 1'b0;
    logic [31:0] data_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    seqgen_top u_dut (
        .clk(clk), .rst(rst), .sel_i(sel_i),
        .load_i(load_i), .adv_i(adv_i), .data_o(data_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] ref_seed(input logic [3:0] p);
        case (p)
            4'd0: return 32'h0000_0000;
            4'd1: return 32'hFFFF_FFFF;
            4'd2: return 32'h0000_0001;
            4'd3: return 32'hFFFF_FFFE;
            4'd4: return 32'hFFFF_FFFF;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] ref_next(input logic [3:0] p, input logic [31:0] x);
        logic [31:0] t;
        case (p)
            4'd0: return x + 32'd4;
            4'd1: return x - 32'd4;
            4'd2, 4'd3: return (x << 1) | (x >> 31);
            4'd4: begin
                t = x;
                t[0] = x[21] ^ x[5];
                return (t << 1) | (t >> 31);
            end
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // drive one edge with the given strobes, sample just after it
    task automatic cyc(input logic l, input logic a, input logic [3:0] s);
        sel_i = s; load_i = l; adv_i = a;
        @(posedge clk); #1;
        load_i = 1'b0; adv_i = 1'b0;
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset word", data_o, 32'h0);
        rst = 1'b0;
        cyc(1'b0, 1'b1, 4'd3);
        check("R1 default pattern advance", data_o, 32'h4);
    endtask

    task automatic t_pattern(input string req, input logic [3:0] p, input int n);
        logic [31:0] exp;
        int bad = 0;
        cyc(1'b1, 1'b0, p);
        exp = ref_seed(p);
        check({req, " seed"}, data_o, exp);
        for (int i = 0; i < n; i++) begin
            cyc(1'b0, 1'b1, p);
            exp = ref_next(p, exp);
            if (data_o !== exp && bad == 0) begin
                bad = 1;
                check({req, " step"}, data_o, exp);
            end
        end
        if (bad == 0) check({req, " sequence end"}, data_o, exp);
    endtask

    task automatic t_unsupported(input logic [3:0] p);
        cyc(1'b0, 1'b1, 4'd2);
        cyc(1'b1, 1'b0, p);
        check("R7 unsupported seed", data_o, 32'h0);
        cyc(1'b0, 1'b1, p);
        cyc(1'b0, 1'b1, p);
        check("R7 unsupported next", data_o, 32'h0);
    endtask

    task automatic t_priority;
        cyc(1'b1, 1'b0, 4'd2);
        cyc(1'b0, 1'b1, 4'd2);
        cyc(1'b0, 1'b1, 4'd2);
        check("R8 setup", data_o, 32'h4);
        cyc(1'b1, 1'b1, 4'd3);
        check("R8 load beats advance", data_o, 32'hFFFF_FFFE);
    endtask

    task automatic t_hold;
        cyc(1'b1, 1'b0, 4'd0);
        cyc(1'b0, 1'b1, 4'd0);
        cyc(1'b0, 1'b1, 4'd0);
        for (int i = 0; i < 6; i++) cyc(1'b0, 1'b0, 4'(i + 1));
        check("R9 idle hold", data_o, 32'h8);
    endtask

    task automatic t_capture;
        cyc(1'b1, 1'b0, 4'd2);
        cyc(1'b0, 1'b1, 4'd0);
        cyc(1'b0, 1'b1, 4'd7);
        check("R10 captured code used", data_o, 32'h4);
        cyc(1'b1, 1'b0, 4'd1);
        cyc(1'b0, 1'b1, 4'd0);
        check("R10 captured dec code", data_o, 32'hFFFF_FFFB);
    endtask

    initial begin
        t_reset();
        t_pattern("R2", 4'd0, 20);
        t_pattern("R3", 4'd1, 20);
        t_pattern("R4", 4'd2, 40);
        t_pattern("R5", 4'd3, 40);
        t_pattern("R6", 4'd4, 80);
        t_unsupported(4'd5);
        t_unsupported(4'd9);
        t_unsupported(4'd15);
        t_priority();
        t_hold();
        t_capture();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=expired expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule